// File: doc/BRIEF.md
# HDB3 Line Transmitter with Code-Error and Alarm-Signal Insertion

This block turns a serial NRZ transmit stream into the two pulse rails that drive a line interface, one rail for positive marks and one for negative marks, using HDB3 zero substitution. It advances one bit each time `rec_tick` pulses in the system clock domain. Each bit leaves the rails exactly four bit periods after it was presented. That four-bit delay is what lets the encoder see a whole run of four zeros before it has to commit to a B00V or 000V substitution.

Two test and maintenance functions are added on top of the plain encoder. The first deliberately inserts code errors. Each error is a data mark sent with the same polarity as the pulse before it. The errors are sent once, at one of two programmable rates, or on every mark. The second replaces the line signal with an alarm indication signal (an all-ones stream of alternating marks) paced by a free-running local reference tick. This replacement happens either when it is forced, or automatically when dejitter operation is selected, automatic alarm is enabled and the PLL reports loss of lock. The data rails and the transmit clock output both switch to this source.

All control inputs are registered once inside the block and reset to 0. A control change therefore takes effect one system clock after it is applied.

Top module: `hdb3_tx`

## Requirements
- R1: `line_pos` and `line_neg` are never high in the same cycle; a positive mark is shown as `line_pos`=1, a negative mark as `line_neg`=1, a space as both 0.
- R2: Data ones alternate in polarity. Every run of four zeros is replaced by 000V when an odd number of pulses (data marks and B pulses) has been sent since the last V, and by B00V when the count is even. B alternates like a data mark. V repeats the polarity of the pulse before it and clears the count. The first mark after reset is positive and the count starts even, so no more than three consecutive spaces ever appear.
- R3: A bit presented with `rec_tick` number k (counting from 0 after reset) appears on the rails after `rec_tick` number k+4. The outputs for the first four ticks after reset are spaces.
- R4: While `ins_bpv` is 0, no code error is sent, whatever `err_rep` holds.
- R5: With `err_rep`=00, each 0-to-1 change of `ins_bpv` causes exactly one error, on the next data mark sent. An error is a data mark with the same polarity as the preceding pulse. Later marks alternate from it, and it still counts as a pulse for R2.
- R6: With `err_rep`=11 and `ins_bpv`=1, every data mark is an error as defined in R5. B and V pulses and the substitution choice are unaffected.
- R7: With `ins_bpv`=1, `err_rep`=01 sends one error per 2^ERR_A_LOG2 bit periods (default 2^10), and `err_rep`=10 sends one per 2^ERR_B_LOG2 bit periods (default 2^13). Each error lands on the next data mark after the count completes.
- R8: While `force_ais` is 1, each `ref_tick` sends one mark on the rails with polarity alternating tick to tick, and `line_clk` pulses one cycle after each `ref_tick` instead of after `rec_tick`.
- R9: With `dejitter_mode`=1, `auto_ais_en`=1 and `pll_locked`=0, the alarm signal of R8 is sent. If `auto_ais_en` is 0, `dejitter_mode` is 0 or `pll_locked` is 1 (and `force_ais` is 0), normal data and the `rec_tick` clock are sent.
- R10: After reset all controls read as 0. The rails are spaces, and `line_clk` pulses one cycle after each `rec_tick`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| rec_tick | input | 1 | One-cycle strobe per transmit bit period (recovered timing) |
| ref_tick | input | 1 | One-cycle strobe from the free-running local reference |
| nrz_in | input | 1 | Transmit data bit, sampled on `rec_tick` |
| force_ais | input | 1 | 1 forces the alarm signal on data and clock |
| ins_bpv | input | 1 | 1 enables code-error insertion |
| auto_ais_en | input | 1 | 1 lets PLL loss of lock start the alarm signal in dejitter mode |
| err_rep | input | 2 | Error repetition: 00 once, 01 rate A, 10 rate B, 11 every mark |
| dejitter_mode | input | 1 | 1 selects dejitter operation |
| pll_locked | input | 1 | 1 when the PLL is locked |
| line_pos | output | 1 | Positive-mark rail |
| line_neg | output | 1 | Negative-mark rail |
| line_clk | output | 1 | Transmit clock pulse, one cycle wide |

## Verification
The encoder is driven with every 8-bit pattern back to back, which produces zero runs of every length and both substitution parities, including a B00V straight after reset. That stream is sent with `err_rep` set to 11 but `ins_bpv` low, so the same run also shows that no errors leak through. Sparse pseudo-random streams are then sent with single-shot and every-mark errors. These streams separate an error that wrongly touches the parity count or the B/V polarity from a correct one. All-ones streams measure the two error rates. Each combination of force, enable, dejitter and lock is also applied, and the bench reads the clock output to see whether the data and clock came from the recovered tick or the reference tick.

// File: rtl/hdb3_tx_pkg.sv
package hdb3_tx_pkg;

  localparam int RUN_LEN = 4;

  typedef enum logic [2:0] {
    SYM_IDLE,
    SYM_ZERO,
    SYM_ONE,
    SYM_BFILL,
    SYM_VIOL
  } sym_e;

  typedef enum logic [1:0] {
    REP_SINGLE = 2'b00,
    REP_RATE_A = 2'b01,
    REP_RATE_B = 2'b10,
    REP_EVERY  = 2'b11
  } rep_e;

  typedef struct packed {
    logic force_ais;
    logic ins_err;
    logic auto_ais;
    rep_e rep;
    logic dejitter;
    logic locked;
  } ctrl_t;

endpackage

// File: rtl/hdb3_encoder.sv
module hdb3_encoder
  import hdb3_tx_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic adv,
  input  logic din,
  input  logic err_arm,
  output logic out_p,
  output logic out_n,
  output logic data_mark
);

  localparam int ZRUN_W = 3;

  sym_e line_q [RUN_LEN];
  sym_e line_d [RUN_LEN];
  logic last_pol_q, last_pol_d;
  logic odd_q, odd_d;
  logic pulse, pol;
  logic window_zero;
  sym_e head;

  assign head      = line_q[RUN_LEN-1];
  assign data_mark = (head == SYM_ONE);

  // Emit the oldest symbol and update polarity and parity.
  always_comb begin
    pulse      = 1'b0;
    pol        = last_pol_q;
    last_pol_d = last_pol_q;
    odd_d      = odd_q;
    case (head)
      SYM_ONE: begin
        pulse = 1'b1;
        odd_d = ~odd_q;
        if (!err_arm) begin
          last_pol_d = ~last_pol_q;
          pol        = ~last_pol_q;
        end
      end
      SYM_BFILL: begin
        pulse      = 1'b1;
        odd_d      = ~odd_q;
        last_pol_d = ~last_pol_q;
        pol        = ~last_pol_q;
      end
      SYM_VIOL: begin
        pulse = 1'b1;
        odd_d = 1'b0;
      end
      default: ;
    endcase
  end

  assign out_p = pulse & pol;
  assign out_n = pulse & ~pol;

  // Shift in the new bit and look for a fresh run of four zeros.
  always_comb begin
    window_zero = ~din;
    for (int i = 0; i < RUN_LEN-1; i++) begin
      if (line_q[i] != SYM_ZERO) window_zero = 1'b0;
    end
    line_d[0] = din ? SYM_ONE : SYM_ZERO;
    for (int i = 1; i < RUN_LEN; i++) line_d[i] = line_q[i-1];
    if (window_zero) begin
      line_d[0] = SYM_VIOL;
      if (!odd_d) line_d[RUN_LEN-1] = SYM_BFILL;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < RUN_LEN; i++) line_q[i] <= SYM_IDLE;
      last_pol_q <= 1'b0;
      odd_q      <= 1'b0;
    end else if (adv) begin
      for (int i = 0; i < RUN_LEN; i++) line_q[i] <= line_d[i];
      last_pol_q <= last_pol_d;
      odd_q      <= odd_d;
    end
  end

  // Count consecutive spaces sent; HDB3 never allows four.
  logic [ZRUN_W-1:0] zrun_q;
  always_ff @(posedge clk) begin
    if (rst) zrun_q <= '0;
    else if (adv) begin
      if (head == SYM_ZERO) zrun_q <= (zrun_q == '1) ? zrun_q : zrun_q + 1'b1;
      else zrun_q <= '0;
    end
  end

  assert_zero_run_R2: assert property (@(posedge clk) disable iff (rst)
    zrun_q < ZRUN_W'(RUN_LEN));

endmodule

// File: rtl/bpv_scheduler.sv
module bpv_scheduler
  import hdb3_tx_pkg::*;
#(
  parameter int ERR_A_LOG2 = 10,
  parameter int ERR_B_LOG2 = 13
) (
  input  logic clk,
  input  logic rst,
  input  logic adv,
  input  logic ins_err,
  input  rep_e rep,
  input  logic consume,
  output logic err_arm
);

  localparam int CNT_W = (ERR_B_LOG2 > ERR_A_LOG2) ? ERR_B_LOG2 : ERR_A_LOG2;

  logic [CNT_W-1:0] bit_cnt_q;
  logic ins_prev_q, pend_q;
  logic hit_a, hit_b, rise, set_req;

  assign hit_a   = &bit_cnt_q[ERR_A_LOG2-1:0];
  assign hit_b   = &bit_cnt_q[ERR_B_LOG2-1:0];
  assign rise    = ins_err & ~ins_prev_q;
  assign set_req = (rise && rep == REP_SINGLE) ||
                   (adv && ins_err && ((rep == REP_RATE_A && hit_a) ||
                                       (rep == REP_RATE_B && hit_b)));
  assign err_arm = ins_err & (pend_q | (rep == REP_EVERY));

  always_ff @(posedge clk) begin
    if (rst) begin
      bit_cnt_q  <= '0;
      ins_prev_q <= 1'b0;
      pend_q     <= 1'b0;
    end else begin
      if (adv) bit_cnt_q <= bit_cnt_q + 1'b1;
      ins_prev_q <= ins_err;
      pend_q     <= ins_err & ((pend_q & ~consume) | set_req);
    end
  end

  assert_single_needs_edge_R5: assert property (@(posedge clk) disable iff (rst)
    (!pend_q && rep == REP_SINGLE && !(ins_err && !ins_prev_q)) |=> !pend_q);

endmodule

// File: rtl/ais_source.sv
module ais_source (
  input  logic clk,
  input  logic rst,
  input  logic active,
  input  logic ref_tick,
  output logic ais_p,
  output logic ais_n
);

  logic pol_q;

  assign ais_p = pol_q;
  assign ais_n = ~pol_q;

  always_ff @(posedge clk) begin
    if (rst) pol_q <= 1'b0;
    else if (active && ref_tick) pol_q <= ~pol_q;
  end

endmodule

// File: rtl/hdb3_tx.sv
module hdb3_tx
  import hdb3_tx_pkg::*;
#(
  parameter int ERR_A_LOG2 = 10,
  parameter int ERR_B_LOG2 = 13
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       rec_tick,
  input  logic       ref_tick,
  input  logic       nrz_in,
  input  logic       force_ais,
  input  logic       ins_bpv,
  input  logic       auto_ais_en,
  input  logic [1:0] err_rep,
  input  logic       dejitter_mode,
  input  logic       pll_locked,
  output logic       line_pos,
  output logic       line_neg,
  output logic       line_clk
);

  ctrl_t ctrl_q;
  logic  ais_act;
  logic  enc_p, enc_n, data_mark, err_arm;
  logic  ais_p, ais_n;

  always_ff @(posedge clk) begin
    if (rst) ctrl_q <= '0;
    else begin
      ctrl_q.force_ais <= force_ais;
      ctrl_q.ins_err   <= ins_bpv;
      ctrl_q.auto_ais  <= auto_ais_en;
      ctrl_q.rep       <= rep_e'(err_rep);
      ctrl_q.dejitter  <= dejitter_mode;
      ctrl_q.locked    <= pll_locked;
    end
  end

  assign ais_act = ctrl_q.force_ais |
                   (ctrl_q.dejitter & ctrl_q.auto_ais & ~ctrl_q.locked);

  hdb3_encoder u_enc (
    .clk       (clk),
    .rst       (rst),
    .adv       (rec_tick),
    .din       (nrz_in),
    .err_arm   (err_arm),
    .out_p     (enc_p),
    .out_n     (enc_n),
    .data_mark (data_mark)
  );

  bpv_scheduler #(
    .ERR_A_LOG2 (ERR_A_LOG2),
    .ERR_B_LOG2 (ERR_B_LOG2)
  ) u_sched (
    .clk     (clk),
    .rst     (rst),
    .adv     (rec_tick),
    .ins_err (ctrl_q.ins_err),
    .rep     (ctrl_q.rep),
    .consume (rec_tick & data_mark & err_arm),
    .err_arm (err_arm)
  );

  ais_source u_ais (
    .clk      (clk),
    .rst      (rst),
    .active   (ais_act),
    .ref_tick (ref_tick),
    .ais_p    (ais_p),
    .ais_n    (ais_n)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      line_pos <= 1'b0;
      line_neg <= 1'b0;
      line_clk <= 1'b0;
    end else begin
      line_clk <= ais_act ? ref_tick : rec_tick;
      if (ais_act && ref_tick) begin
        line_pos <= ais_p;
        line_neg <= ais_n;
      end else if (!ais_act && rec_tick) begin
        line_pos <= enc_p;
        line_neg <= enc_n;
      end
    end
  end

  assert_rails_exclusive_R1: assert property (@(posedge clk) disable iff (rst)
    !(line_pos && line_neg));

  assert_ais_marks_R8: assert property (@(posedge clk) disable iff (rst)
    (ais_act && ref_tick) |=> (line_pos != line_neg));

  assert_ais_clock_source_R9: assert property (@(posedge clk) disable iff (rst)
    (ais_act && rec_tick && !ref_tick) |=> !line_clk);

  assert_normal_clock_source_R10: assert property (@(posedge clk) disable iff (rst)
    (!ais_act && rec_tick) |=> line_clk);

endmodule

// File: tb/tb_hdb3_tx.sv
module tb_hdb3_tx;

  localparam int RA = 3;
  localparam int RB = 5;
  localparam int MAXN = 2100;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst, rec_tick, ref_tick, nrz_in;
  logic force_ais, ins_bpv, auto_ais_en, dejitter_mode, pll_locked;
  logic [1:0] err_rep;
  logic line_pos, line_neg, line_clk;

  hdb3_tx #(.ERR_A_LOG2(RA), .ERR_B_LOG2(RB)) dut (
    .clk(clk), .rst(rst), .rec_tick(rec_tick), .ref_tick(ref_tick),
    .nrz_in(nrz_in), .force_ais(force_ais), .ins_bpv(ins_bpv),
    .auto_ais_en(auto_ais_en), .err_rep(err_rep),
    .dejitter_mode(dejitter_mode), .pll_locked(pll_locked),
    .line_pos(line_pos), .line_neg(line_neg), .line_clk(line_clk)
  );

  int n_chk = 0;
  int n_fail = 0;
  int bits [MAXN];
  int expv [MAXN];
  int s_rec, s_ref;
  logic c_rec, c_ref;
  int lcg = 12345;

  task automatic chk(input bit ok, input string rq, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
    end
  endtask

  function automatic int rails();
    if (line_pos && line_neg) return 9;
    if (line_pos) return 1;
    if (line_neg) return -1;
    return 0;
  endfunction

  task automatic period(input int b);
    @(negedge clk); rec_tick = 1'b1; nrz_in = b[0];
    @(negedge clk); rec_tick = 1'b0; s_rec = rails(); c_rec = line_clk;
    @(negedge clk); ref_tick = 1'b1;
    @(negedge clk); ref_tick = 1'b0; s_ref = rails(); c_ref = line_clk;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; rec_tick = 0; ref_tick = 0; nrz_in = 0;
    force_ais = 0; ins_bpv = 0; auto_ais_en = 0; err_rep = 2'b00;
    dejitter_mode = 0; pll_locked = 0;
    idle(3);
    rst = 1'b0;
    idle(2);
  endtask

  function automatic int rnd();
    lcg = lcg * 1103515245 + 12345;
    return (lcg >>> 16) & 32'h7fff;
  endfunction

  // Reference HDB3 model over the whole stream, greedy from the left.
  task automatic build_model(input int n, input bit err_all, input int single_from);
    int sym [MAXN];
    int last = -1;
    int par = 0;
    bit spent = 0;
    for (int i = 0; i < n; i++) sym[i] = -1;
    for (int i = 0; i < n; i++) begin
      if (sym[i] < 0) begin
        if (i + 3 < n && bits[i] == 0 && bits[i+1] == 0 && bits[i+2] == 0 && bits[i+3] == 0) begin
          sym[i] = par ? 0 : 2; sym[i+1] = 0; sym[i+2] = 0; sym[i+3] = 3;
        end else sym[i] = bits[i];
      end
      case (sym[i])
        0: expv[i] = 0;
        1: begin
          if (err_all || (single_from >= 0 && !spent && i >= single_from)) begin
            if (!err_all) spent = 1;
            expv[i] = last;
          end else begin
            last = -last; expv[i] = last;
          end
          par ^= 1;
        end
        2: begin last = -last; expv[i] = last; par ^= 1; end
        default: begin expv[i] = last; par = 0; end
      endcase
    end
  endtask

  task automatic run_cmp(input int n, input string rq, input int ctl_at);
    for (int k = 0; k <= n; k++) begin
      if (k == ctl_at) begin idle(2); ins_bpv = 1'b1; idle(3); end
      period(k < n ? bits[k] : 0);
      if (k < 4) chk(s_rec == 0, "R3", s_rec, 0);
      else chk(s_rec == expv[k-4], rq, s_rec, expv[k-4]);
    end
  endtask

  initial begin
    int errs, prev;
    // R10: reset state
    do_reset();
    chk(rails() == 0, "R10", rails(), 0);
    chk(line_clk == 1'b0, "R10", line_clk, 0);

    // R2, R3, R4: every 8-bit pattern, errors requested but ins_bpv low
    for (int p = 0; p < 256; p++)
      for (int j = 0; j < 8; j++) bits[p*8+j] = (p >> (7-j)) & 1;
    build_model(2048, 0, -1);
    do_reset();
    err_rep = 2'b11;
    period(bits[0]);
    chk(c_rec == 1'b1 && c_ref == 1'b0, "R10", c_rec, 1);
    chk(s_rec == 0, "R3", s_rec, 0);
    for (int k = 1; k <= 2048; k++) begin
      period(k < 2048 ? bits[k] : 0);
      if (k < 4) chk(s_rec == 0, "R3", s_rec, 0);
      else chk(s_rec == expv[k-4], "R2 R4 latency R3", s_rec, expv[k-4]);
    end

    // R5: single error after a rising edge of ins_bpv
    for (int i = 0; i < 300; i++) bits[i] = (rnd() % 3) != 0 ? 1 : 0;
    build_model(300, 0, 96);
    do_reset();
    err_rep = 2'b00;
    run_cmp(300, "R5", 100);

    // R6: every data mark is an error, sparse stream
    for (int i = 0; i < 400; i++) bits[i] = (rnd() % 4) == 0 ? 1 : 0;
    build_model(400, 1, -1);
    do_reset();
    err_rep = 2'b11; ins_bpv = 1'b1;
    idle(3);
    run_cmp(400, "R6", -1);

    // R7: rate A and rate B on an all-ones stream
    for (int m = 1; m <= 2; m++) begin
      do_reset();
      err_rep = m[1:0]; ins_bpv = 1'b1;
      idle(3);
      errs = 0; prev = 0;
      for (int k = 0; k < 70; k++) begin
        period(1);
        if (k >= 4) begin
          if (s_rec != 0 && s_rec == prev) errs++;
          if (s_rec != 0) prev = s_rec;
        end
      end
      if (m == 1) chk(errs >= 7 && errs <= 10, "R7 rate A", errs, 8);
      else chk(errs >= 1 && errs <= 3, "R7 rate B", errs, 2);
    end

    // R8: forced alarm signal
    do_reset();
    force_ais = 1'b1;
    idle(3);
    prev = 0;
    for (int k = 0; k < 8; k++) begin
      period(0);
      chk(c_ref == 1'b1 && c_rec == 1'b0, "R8 clock", c_ref, 1);
      chk(s_ref == 1 || s_ref == -1, "R8 mark", s_ref, 1);
      if (k > 0) chk(s_ref == -prev, "R8 alternate", s_ref, -prev);
      prev = s_ref;
    end
    force_ais = 1'b0;
    idle(3);
    period(0); period(0);
    chk(c_rec == 1'b1 && c_ref == 1'b0, "R8 release", c_rec, 1);

    // R9: automatic alarm combinations
    for (int c = 0; c < 4; c++) begin
      dejitter_mode = (c != 3); auto_ais_en = (c != 2); pll_locked = (c == 1);
      idle(3);
      period(1); period(1);
      if (c == 0) begin
        chk(c_ref == 1'b1 && c_rec == 1'b0, "R9 auto on", c_ref, 1);
        chk(s_ref == 1 || s_ref == -1, "R9 mark", s_ref, 1);
      end else
        chk(c_rec == 1'b1 && c_ref == 1'b0, "R9 auto off", c_rec, 1);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule